// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer with Collision Detection

This block produces the repeated-start condition for a multi-master I2C master and watches for a second master while it does so. It drives the bus through two open-drain pull-down enables, one for SDA and one for SCL. A drive enable of 1 pulls its line low and 0 releases it. The block reads the lines back through a two-flop synchronizer. A single down-counter, loaded from the `reload_i` value, sets the length of every timed phase. Each timed phase lasts `reload_i + 1` clock cycles, so a reload of zero gives a one-cycle phase.

A `start_i` pulse in idle starts the sequence, which runs in five steps:
1. SDA is released while SCL is held low, for one timed phase.
2. SCL is released. SDA is sampled at the first synchronized SCL high that follows a synchronized SCL low.
3. With both lines released, a second timed phase runs while SCL is watched.
4. SDA is pulled low for a third timed phase.
5. SCL is pulled low and the sequence completes.

Two conditions mean that arbitration is lost. The first is SDA reading low when SCL is seen high. The second is SCL falling during the second phase, before this master has pulled SDA. On either one the block lets go of both lines, returns to idle and sets a sticky collision flag. A clean completion sets a sticky done flag and leaves both lines pulled low for the data transfer that follows.

Top module: `i2c_rstart_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `coll_o`, `sda_oe_o` and `scl_oe_o` are all 0.
- R2: A `start_i` pulse sampled in idle at clock edge E0 makes `busy_o`=1, `sda_oe_o`=0 and `scl_oe_o`=1 after E0. `scl_oe_o` stays 1 through edge E(N), where N is `reload_i`, and drops to 0 after E(N+1).
- R3: The bus inputs reach the comparison logic two clock edges after they change. SDA is sampled at the first synchronized SCL high that follows a synchronized SCL low inside the sequence. With a quiet bus this sampling happens at edge E(N+4).
- R4: If SDA reads low at that sampling point, `coll_o` rises after E(N+4). Both drive enables are then 0, `busy_o` is 0 and `done_o` stays 0.
- R5: If SDA reads high, a second phase of N+1 cycles runs with both lines released. A synchronized SCL low during that phase sets `coll_o` and releases both lines. An external SCL pull that starts after edge E(N+4+j), with 0 <= j <= N-2, sets `coll_o` after E(N+7+j).
- R6: SDA going low during the second phase is not a collision, and the sequence completes at the normal time.
- R7: After the second phase `sda_oe_o` rises after E(2N+5) while `scl_oe_o` is 0. After a further N+1 cycles `done_o` rises after E(3N+6), whatever the level of SCL. From then on both drive enables stay 1 until the next start.
- R8: A `reload_i` of 0 gives one-cycle phases, and the timing of R2 to R7 holds with N=0.
- R9: `done_o` and `coll_o` stay set until a one-cycle pulse on `clr_done_i` or `clr_coll_i` clears them, one edge later.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect: the completion time is unchanged, and `busy_o` is 0 after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a repeated start (accepted in idle only) |
| clr_done_i | input | 1 | Clear the done flag |
| clr_coll_i | input | 1 | Clear the collision flag |
| reload_i | input | CNT_W | Length of each phase minus one, in cycles |
| sda_i | input | 1 | SDA line level, asynchronous |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: repeated start completed |
| coll_o | output | 1 | Sticky: arbitration lost |

## Verification
The assertions assume that `clr_done_i` and `clr_coll_i` are never pulsed in the same cycle that the matching flag rises. They also assume that `reload_i` does not change while a sequence runs. The bench meets both conditions: it changes `reload_i` only in idle, and it pulses a clear only after it has seen the flag settle. The bench models the bus as a wired-AND of the block's enables and a second master. That second master pulls SDA or SCL only at chosen cycle offsets after the start edge, which keeps every expected edge at a fixed arithmetic position.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_REL,
    ST_SCL_REL,
    ST_HOLD,
    ST_SDA_DRV
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_brg.sv
module i2c_rs_brg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_rs_flags.sv
module i2c_rs_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_done_i,
  input  logic set_coll_i,
  input  logic clr_done_i,
  input  logic clr_coll_i,
  output logic done_o,
  output logic coll_o
);
  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      coll_o <= 1'b0;
    end else begin
      if (set_done_i)      done_o <= 1'b1;
      else if (clr_done_i) done_o <= 1'b0;
      if (set_coll_i)      coll_o <= 1'b1;
      else if (clr_coll_i) coll_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic brg_zero_i,
  output logic brg_load_o,
  output logic sda_oe_o,
  output logic scl_oe_o,
  output logic busy_o,
  output logic set_done_o,
  output logic set_coll_o
);
  rs_state_e state_q, state_d;
  logic      own_q, own_d;    // bus held after a clean completion
  logic      seen_q, seen_d;  // synchronized SCL low observed in this sequence

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      own_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
      seen_q  <= seen_d;
    end
  end

  always_comb begin
    state_d    = state_q;
    own_d      = own_q;
    seen_d     = seen_q;
    brg_load_o = 1'b0;
    set_done_o = 1'b0;
    set_coll_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_SDA_REL;
          brg_load_o = 1'b1;
          seen_d     = 1'b0;
        end
      end
      ST_SDA_REL: begin
        if (!scl_s_i) seen_d = 1'b1;
        if (brg_zero_i) state_d = ST_SCL_REL;
      end
      ST_SCL_REL: begin
        if (!scl_s_i) begin
          seen_d = 1'b1;
        end else if (seen_q) begin
          if (!sda_s_i) begin
            set_coll_o = 1'b1;
            own_d      = 1'b0;
            state_d    = ST_IDLE;
          end else begin
            brg_load_o = 1'b1;
            state_d    = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!scl_s_i) begin
          set_coll_o = 1'b1;
          own_d      = 1'b0;
          state_d    = ST_IDLE;
        end else if (brg_zero_i) begin
          brg_load_o = 1'b1;
          state_d    = ST_SDA_DRV;
        end
      end
      ST_SDA_DRV: begin
        if (brg_zero_i) begin
          set_done_o = 1'b1;
          own_d      = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:    begin sda_oe_o = own_q; scl_oe_o = own_q; end
      ST_SDA_REL: begin sda_oe_o = 1'b0;  scl_oe_o = 1'b1;  end
      ST_SDA_DRV: begin sda_oe_o = 1'b1;  scl_oe_o = 1'b0;  end
      default:    begin sda_oe_o = 1'b0;  scl_oe_o = 1'b0;  end
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_done_i,
  input  logic             clr_coll_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             sda_i,
  input  logic             scl_i,
  output logic             sda_oe_o,
  output logic             scl_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             coll_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] bus_s;
  logic             brg_load, brg_zero;
  logic             set_done, set_coll;

  i2c_rs_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  i2c_rs_brg #(.CNT_W(CNT_W)) u_brg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (brg_load),
    .val_i  (reload_i),
    .zero_o (brg_zero)
  );

  i2c_rs_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sda_s_i    (bus_s[0]),
    .scl_s_i    (bus_s[1]),
    .brg_zero_i (brg_zero),
    .brg_load_o (brg_load),
    .sda_oe_o   (sda_oe_o),
    .scl_oe_o   (scl_oe_o),
    .busy_o     (busy_o),
    .set_done_o (set_done),
    .set_coll_o (set_coll)
  );

  i2c_rs_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_done_i (set_done),
    .set_coll_i (set_coll),
    .clr_done_i (clr_done_i),
    .clr_coll_i (clr_coll_i),
    .done_o     (done_o),
    .coll_o     (coll_o)
  );
endmodule

// File: rtl/i2c_rstart_chk.sv
module i2c_rstart_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_done_i,
  input logic clr_coll_i,
  input logic sda_oe_o,
  input logic scl_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic coll_o
);
  assert_seq_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!sda_oe_o && scl_oe_o));

  assert_coll_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) |-> (!sda_oe_o && !scl_oe_o && !busy_o));

  assert_sda_drive_scl_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && busy_o) |-> !scl_oe_o);

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (sda_oe_o && scl_oe_o && !busy_o));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_done_i) |=> done_o);

  assert_coll_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_o && !clr_coll_i) |=> coll_o);

  assert_coll_no_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(coll_o) && $rose(done_o)));
endmodule

bind i2c_rstart_seq i2c_rstart_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_done_i (clr_done_i),
  .clr_coll_i (clr_coll_i),
  .sda_oe_o   (sda_oe_o),
  .scl_oe_o   (scl_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .coll_o     (coll_o)
);

// File: tb/tb_i2c_rstart_seq.sv
`timescale 1ns/1ps
module tb_i2c_rstart_seq;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clr_done = 1'b0, clr_coll = 1'b0;
  logic [CW-1:0] reload = '0;
  logic sda_ext = 1'b0, scl_ext = 1'b0;
  logic sda_oe, scl_oe, busy, done, coll;
  logic sda_line, scl_line;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign sda_line = ~(sda_oe | sda_ext);
  assign scl_line = ~(scl_oe | scl_ext);

  i2c_rstart_seq #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clr_done_i(clr_done),
    .clr_coll_i(clr_coll), .reload_i(reload), .sda_i(sda_line), .scl_i(scl_line),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .busy_o(busy), .done_o(done), .coll_o(coll)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // sda_at: 0 = second master holds SDA from before start, k>0 = from after edge Ek, -1 never
  task automatic run_seq(input int n, input int sda_at, input int scl_at, input int extra_at,
                         output int kd, output int kc, output int krel, output int ksda);
    reload = CW'(n);
    kd = -1; kc = -1; krel = -1; ksda = -1;
    if (sda_at == 0) sda_ext = 1'b1;
    @(negedge clk) start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy && !sda_oe && scl_oe, "R2", {busy, sda_oe, scl_oe}, 3'b101);
    for (int k = 1; k <= 80; k++) begin
      @(posedge clk); #1;
      if (done && kd < 0) kd = k;
      if (coll && kc < 0) kc = k;
      if (!scl_oe && krel < 0) krel = k;
      if (sda_oe && busy && ksda < 0) ksda = k;
      if (k == sda_at) sda_ext = 1'b1;
      if (k == scl_at) scl_ext = 1'b1;
      start = (k == extra_at);
      if (kd >= 0 || kc >= 0) break;
    end
    start = 1'b0;
    sda_ext = 1'b0;
    scl_ext = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_done = 1'b1; clr_coll = 1'b1;
    @(negedge clk); clr_done = 1'b0; clr_coll = 1'b0;
    chk(!done && !coll, "R9", {done, coll}, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int kd, kc, krel, ksda;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !coll && !sda_oe && !scl_oe, "R1",
        {busy, done, coll, sda_oe, scl_oe}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // clean sequences, R2 R3 R7 R8
    for (int n = 0; n < 8; n++) begin
      run_seq(n, -1, -1, -1, kd, kc, krel, ksda);
      chk(krel == n + 1, "R2", krel, n + 1);
      chk(ksda == 2*n + 5, "R7", ksda, 2*n + 5);
      chk(kd == 3*n + 6, n == 0 ? "R8" : "R7", kd, 3*n + 6);
      chk(kc < 0, "R3", kc, -1);
      chk(sda_oe && scl_oe && !busy, "R7", {sda_oe, scl_oe, busy}, 3'b110);
      repeat (3) @(posedge clk);
      #1;
      chk(done && sda_oe && scl_oe, "R9", {done, sda_oe, scl_oe}, 3'b111);
      clear_flags();
    end

    // SDA low at sample point, R4
    for (int n = 0; n < 8; n++) begin
      run_seq(n, 0, -1, -1, kd, kc, krel, ksda);
      chk(kc == n + 4, "R4", kc, n + 4);
      chk(!done && !sda_oe && !scl_oe && !busy, "R4", {done, sda_oe, scl_oe, busy}, 0);
      repeat (2) @(posedge clk);
      #1;
      chk(coll && !done, "R9", {coll, done}, 2'b10);
      clear_flags();
    end

    // SCL pulled low during the second phase, R5
    for (int n = 2; n < 7; n++) begin
      for (int j = 0; j <= n - 2; j++) begin
        run_seq(n, -1, n + 4 + j, -1, kd, kc, krel, ksda);
        chk(kc == n + 7 + j, "R5", kc, n + 7 + j);
        chk(kd < 0 && !sda_oe && !scl_oe, "R5", {sda_oe, scl_oe}, 0);
        clear_flags();
      end
    end

    // SCL pull seen only after SDA is driven: completion regardless of SCL, R7
    for (int n = 1; n < 6; n++) begin
      run_seq(n, -1, 2*n + 3, -1, kd, kc, krel, ksda);
      chk(kd == 3*n + 6 && kc < 0, "R7", kd, 3*n + 6);
      clear_flags();
    end

    // SDA falling during the second phase is not a collision, R6
    for (int n = 0; n < 6; n++) begin
      run_seq(n, n + 5, -1, -1, kd, kc, krel, ksda);
      chk(kd == 3*n + 6 && kc < 0, "R6", kd, 3*n + 6);
      clear_flags();
    end

    // start while busy is ignored, R10
    for (int n = 1; n < 5; n++) begin
      run_seq(n, -1, -1, n + 2, kd, kc, krel, ksda);
      chk(kd == 3*n + 6, "R10", kd, 3*n + 6);
      @(posedge clk); #1;
      chk(!busy, "R10", busy, 0);
      clear_flags();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule